// File: doc/BRIEF.md
# Iterative AES-128 Block Encryptor

This block enciphers one 128-bit block under a 128-bit key with the AES-128 cipher. One round of cipher logic is built as combinational hardware. A state register sends that round's result back into the same logic on the next clock, so all ten rounds reuse one datapath. The round key is not stored as a full schedule. A key register holds the current subkey, and one key-expansion step beside the datapath advances it each cycle, just before the round that needs it.

Software or a surrounding engine places the plaintext and key on the inputs and raises `start` for one cycle while the block is idle. The block then stays busy for ten cycles. It raises `done` for one cycle when the last round has been written. The ciphertext stays on the output until the next accepted start. A new block can be accepted in the same cycle that `done` is high, so throughput is one block every eleven cycles.

Top module: `aes128_iter_enc`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `busy` and `done` are 0 and `ciphertext` is all zeros.
- R2: A `start` sampled at a rising edge while `busy` is 0 sets `busy` to 1 after that edge. `busy` stays 1 for the following nine cycles.
- R3: `done` is high after exactly the tenth rising edge that follows the accepting edge. It stays high for one cycle only, and `busy` is 0 in that same cycle.
- R4: Byte 0 of every 128-bit value is bits [127:120]. For key 000102030405060708090A0B0C0D0E0F and plaintext 00112233445566778899AABBCCDDEEFF, `ciphertext` reads 69C4E0D86A7B0430D8CDB78070B4C55A when `done` is high.
- R5: For any key and plaintext, `ciphertext` equals the AES-128 encryption when `done` is high. That is ten rounds; the tenth has no column mixing, and the round constants run 01,02,04,08,10,20,40,80,1B,36.
- R6: A `start` sampled while `busy` is 1 is ignored. It changes neither the result nor the cycle in which `done` rises.
- R7: After `done`, `ciphertext` holds its value while `start` stays low, whatever the `plaintext` and `key` inputs do.
- R8: A `start` presented in the cycle where `done` is high is accepted. This gives back-to-back blocks eleven cycles apart, each with a correct result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin encryption; accepted only when idle |
| plaintext | input | 128 | Block to encrypt, byte 0 in bits [127:120] |
| key | input | 128 | Cipher key, byte 0 in bits [127:120] |
| busy | output | 1 | High while rounds are in progress |
| done | output | 1 | One-cycle pulse when the ciphertext is ready |
| ciphertext | output | 128 | Encrypted block, held until the next accepted start |

## Verification
AES spreads every bit across the whole block within two rounds. So a bad S-box entry, a misrouted row shift, a wrong mixing coefficient or a wrong round constant shows up as a ciphertext mismatch the first time that path is used. It appears at the `done` cycle of that block, ten cycles after the start. Walking a single set bit through plaintext and key drives every byte lane through both the datapath and the key step. A fault in the round counter appears sooner and in a different way: `done` rises in the wrong cycle or in more than one cycle, or `busy` ends early. An ignored start that wrongly restarts the block shifts the `done` cycle and corrupts the result.

// File: rtl/aes128_pkg.sv
package aes128_pkg;

    localparam int BLK_W      = 128;
    localparam int NUM_BYTES  = BLK_W / 8;
    localparam int NUM_WORDS  = BLK_W / 32;
    localparam int NUM_ROUNDS = 10;
    localparam int CNT_W      = $clog2(NUM_ROUNDS + 1);

    typedef logic [7:0]                    byte_t;
    typedef logic [0:NUM_BYTES-1][7:0]     block_t;
    typedef logic [0:NUM_WORDS-1][31:0]    kwords_t;
    typedef logic [CNT_W-1:0]              rnd_t;

    typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} phase_e;

    typedef struct packed {
        phase_e phase;
        rnd_t   rnd;
        logic   fin;
    } ctrl_t;

    function automatic byte_t gf_xtime(input byte_t a);
        return a[7] ? ((a << 1) ^ 8'h1b) : (a << 1);
    endfunction

    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t acc = 8'h00;
        byte_t sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_xtime(sh);
        end
        return acc;
    endfunction

    // Multiplicative inverse as a^254 by square-and-multiply; 0 maps to 0.
    function automatic byte_t gf_inv(input byte_t a);
        byte_t r = 8'h01;
        for (int i = 7; i >= 0; i--) begin
            r = gf_mul(r, r);
            if (i != 0) r = gf_mul(r, a);
        end
        return r;
    endfunction

    function automatic byte_t rotl8(input byte_t v, input int n);
        return byte_t'((v << n) | (v >> (8 - n)));
    endfunction

    function automatic byte_t sbox(input byte_t a);
        byte_t v = gf_inv(a);
        return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
    endfunction

    function automatic byte_t rcon(input rnd_t r);
        byte_t c = 8'h01;
        for (int i = 1; i < NUM_ROUNDS; i++) begin
            if (rnd_t'(i) < r) c = gf_xtime(c);
        end
        return c;
    endfunction

endpackage

// File: rtl/aes128_round.sv
module aes128_round
    import aes128_pkg::*;
(
    input  block_t st_i,
    input  block_t rk_i,
    input  logic   last_i,
    output block_t st_o
);
    block_t sub_b;
    block_t shf_b;
    block_t mix_b;

    for (genvar gi = 0; gi < NUM_BYTES; gi++) begin : g_sub
        assign sub_b[gi] = sbox(st_i[gi]);
    end

    for (genvar gc = 0; gc < NUM_WORDS; gc++) begin : g_col
        for (genvar gr = 0; gr < 4; gr++) begin : g_row
            assign shf_b[gr + 4*gc] = sub_b[gr + 4*((gc + gr) % NUM_WORDS)];
        end

        byte_t a0, a1, a2, a3;
        assign a0 = shf_b[4*gc + 0];
        assign a1 = shf_b[4*gc + 1];
        assign a2 = shf_b[4*gc + 2];
        assign a3 = shf_b[4*gc + 3];

        assign mix_b[4*gc + 0] = gf_xtime(a0) ^ gf_xtime(a1) ^ a1 ^ a2 ^ a3;
        assign mix_b[4*gc + 1] = a0 ^ gf_xtime(a1) ^ gf_xtime(a2) ^ a2 ^ a3;
        assign mix_b[4*gc + 2] = a0 ^ a1 ^ gf_xtime(a2) ^ gf_xtime(a3) ^ a3;
        assign mix_b[4*gc + 3] = gf_xtime(a0) ^ a0 ^ a1 ^ a2 ^ gf_xtime(a3);
    end

    assign st_o = (last_i ? shf_b : mix_b) ^ rk_i;

endmodule

// File: rtl/aes128_keystep.sv
module aes128_keystep
    import aes128_pkg::*;
(
    input  kwords_t k_i,
    input  rnd_t    rnd_i,
    output kwords_t k_o
);
    logic [31:0] tw;

    assign tw = {sbox(k_i[NUM_WORDS-1][23:16]) ^ rcon(rnd_i),
                 sbox(k_i[NUM_WORDS-1][15:8]),
                 sbox(k_i[NUM_WORDS-1][7:0]),
                 sbox(k_i[NUM_WORDS-1][31:24])};

    assign k_o[0] = k_i[0] ^ tw;
    for (genvar gw = 1; gw < NUM_WORDS; gw++) begin : g_chain
        assign k_o[gw] = k_i[gw] ^ k_o[gw-1];
    end

endmodule

// File: rtl/aes128_ctrl.sv
module aes128_ctrl
    import aes128_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic last_o,
    output rnd_t rnd_o,
    output logic busy_o,
    output logic done_o
);
    ctrl_t cs;

    assign load_o = start_i && (cs.phase == ST_IDLE);
    assign step_o = (cs.phase == ST_RUN);
    assign last_o = (cs.rnd == rnd_t'(NUM_ROUNDS));
    assign rnd_o  = cs.rnd;
    assign busy_o = step_o;
    assign done_o = cs.fin;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs <= '{phase: ST_IDLE, rnd: '0, fin: 1'b0};
        end else begin
            cs.fin <= 1'b0;
            if (load_o) begin
                cs.phase <= ST_RUN;
                cs.rnd   <= rnd_t'(1);
            end else if (step_o) begin
                if (last_o) begin
                    cs.phase <= ST_IDLE;
                    cs.rnd   <= '0;
                    cs.fin   <= 1'b1;
                end else begin
                    cs.rnd <= cs.rnd + rnd_t'(1);
                end
            end
        end
    end

endmodule

// File: rtl/aes128_iter_enc.sv
module aes128_iter_enc
    import aes128_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [BLK_W-1:0] plaintext,
    input  logic [BLK_W-1:0] key,
    output logic             busy,
    output logic             done,
    output logic [BLK_W-1:0] ciphertext
);
    block_t  st_q, st_nx;
    kwords_t key_q, key_nx;
    logic    load, step, last;
    rnd_t    rnd;

    aes128_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start_i (start),
        .load_o  (load),
        .step_o  (step),
        .last_o  (last),
        .rnd_o   (rnd),
        .busy_o  (busy),
        .done_o  (done)
    );

    aes128_keystep u_kstep (
        .k_i   (key_q),
        .rnd_i (rnd),
        .k_o   (key_nx)
    );

    aes128_round u_round (
        .st_i   (st_q),
        .rk_i   (block_t'(key_nx)),
        .last_i (last),
        .st_o   (st_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= '0;
            key_q <= '0;
        end else if (load) begin
            st_q  <= block_t'(plaintext ^ key);
            key_q <= kwords_t'(key);
        end else if (step) begin
            st_q  <= st_nx;
            key_q <= key_nx;
        end
    end

    assign ciphertext = st_q;

endmodule

// File: rtl/aes128_iter_chk.sv
module aes128_iter_chk
    import aes128_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [BLK_W-1:0] ciphertext
);
    logic           active;
    logic [CNT_W:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (start && !busy) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (done) begin
            active <= 1'b0;
        end else if (active) begin
            cnt <= cnt + 1'b1;
        end
    end

    a_r1_idle_after_reset: assert property (@(posedge clk)
        $fell(rst) |-> (!busy && !done && ciphertext == '0));

    a_r2_busy_after_start: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    a_r2_busy_tracked: assert property (@(posedge clk) disable iff (rst)
        busy |-> active);

    a_r3_done_latency: assert property (@(posedge clk) disable iff (rst)
        done |-> (active && cnt == (CNT_W+1)'(NUM_ROUNDS)));

    a_r3_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r3_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r7_hold_output: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(ciphertext));

endmodule

bind aes128_iter_enc aes128_iter_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .ciphertext (ciphertext)
);

// File: tb/tb_aes128_iter_enc.sv
`timescale 1ns/1ps
module tb_aes128_iter_enc;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [127:0] pt = '0;
    logic [127:0] key = '0;
    logic         busy, done;
    logic [127:0] ct;

    int checks = 0;
    int fails  = 0;
    logic [7:0] sb [256];

    always #2.5 clk = ~clk;

    aes128_iter_enc dut (
        .clk(clk), .rst(rst), .start(start), .plaintext(pt), .key(key),
        .busy(busy), .done(done), .ciphertext(ct)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p = 8'h00;
        logic [7:0] x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p = p ^ x;
            x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
        end
        return p;
    endfunction

    function automatic logic [7:0] rl(input logic [7:0] v, input int n);
        logic [7:0] r = v;
        for (int i = 0; i < n; i++) r = {r[6:0], r[7]};
        return r;
    endfunction

    task automatic build_sbox();
        for (int x = 0; x < 256; x++) begin
            logic [7:0] inv = 8'h00;
            for (int z = 1; z < 256; z++)
                if (bmul(8'(x), 8'(z)) == 8'h01) inv = 8'(z);
            sb[x] = inv ^ rl(inv, 1) ^ rl(inv, 2) ^ rl(inv, 3) ^ rl(inv, 4) ^ 8'h63;
        end
    endtask

    function automatic logic [127:0] ref_enc(input logic [127:0] p, input logic [127:0] k);
        logic [31:0] w [44];
        logic [7:0]  s [16];
        logic [7:0]  t [16];
        logic [7:0]  rc = 8'h01;
        logic [127:0] o;
        for (int i = 0; i < 4; i++) w[i] = k[127 - 32*i -: 32];
        for (int i = 4; i < 44; i++) begin
            logic [31:0] tmp = w[i-1];
            if (i % 4 == 0) begin
                tmp = {sb[tmp[23:16]], sb[tmp[15:8]], sb[tmp[7:0]], sb[tmp[31:24]]} ^ {rc, 24'h0};
                rc = bmul(rc, 8'h02);
            end
            w[i] = w[i-4] ^ tmp;
        end
        for (int j = 0; j < 16; j++) s[j] = p[127 - 8*j -: 8] ^ w[j/4][31 - 8*(j%4) -: 8];
        for (int r = 1; r <= 10; r++) begin
            for (int j = 0; j < 16; j++) t[j] = sb[s[j]];
            for (int c = 0; c < 4; c++)
                for (int q = 0; q < 4; q++) s[q + 4*c] = t[q + 4*((c + q) % 4)];
            if (r < 10) begin
                for (int c = 0; c < 4; c++) begin
                    logic [7:0] a0 = s[4*c], a1 = s[4*c+1], a2 = s[4*c+2], a3 = s[4*c+3];
                    s[4*c]   = bmul(a0, 8'h02) ^ bmul(a1, 8'h03) ^ a2 ^ a3;
                    s[4*c+1] = a0 ^ bmul(a1, 8'h02) ^ bmul(a2, 8'h03) ^ a3;
                    s[4*c+2] = a0 ^ a1 ^ bmul(a2, 8'h02) ^ bmul(a3, 8'h03);
                    s[4*c+3] = bmul(a0, 8'h03) ^ a1 ^ a2 ^ bmul(a3, 8'h02);
                end
            end
            for (int j = 0; j < 16; j++) s[j] = s[j] ^ w[4*r + j/4][31 - 8*(j%4) -: 8];
        end
        for (int j = 0; j < 16; j++) o[127 - 8*j -: 8] = s[j];
        return o;
    endfunction

    // Called at a falling edge; returns at the falling edge where done is seen.
    task automatic run(input logic [127:0] p, input logic [127:0] k, input bit poke,
                       output logic [127:0] res, output int lat);
        pt = p; key = k; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 20) begin
            chk(busy === 1'b1, "R2 busy during rounds", 128'(busy), 128'd1);
            if (poke && lat == 3) begin start = 1'b1; pt = ~p; key = k ^ 128'h5a; end
            if (poke && lat == 6) start = 1'b0;
            @(negedge clk);
            lat++;
        end
        chk(busy === 1'b0, "R3 busy low with done", 128'(busy), 128'd0);
        res = ct;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [127:0] res, exp, held, k1, p1;
        int lat;
        build_sbox();
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0 && ct === '0, "R1 reset state", ct, 128'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0 && ct === '0, "R1 after reset", ct, 128'd0);

        // R4 byte order and known vector
        run(128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f, 0, res, lat);
        chk(res === 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R4 known vector", res,
            128'h69c4e0d86a7b0430d8cdb78070b4c55a);
        chk(lat == 10, "R3 latency", 128'(lat), 128'd10);
        held = ct;
        for (int i = 0; i < 5; i++) begin
            pt = {4{32'(i) * 32'h9e3779b9}}; key = ~pt;
            @(negedge clk);
            chk(done === 1'b0, "R3 done one cycle", 128'(done), 128'd0);
            chk(ct === held, "R7 output held", ct, held);
        end

        // R5 second standard vector
        run(128'h3243f6a8885a308d313198a2e0370734, 128'h2b7e151628aed2a6abf7158809cf4f3c, 0, res, lat);
        chk(res === 128'h3925841d02dc09fbdc118597196a0b32, "R5 second vector", res,
            128'h3925841d02dc09fbdc118597196a0b32);
        chk(res === ref_enc(128'h3243f6a8885a308d313198a2e0370734, 128'h2b7e151628aed2a6abf7158809cf4f3c),
            "R5 model agrees", res, 128'h3925841d02dc09fbdc118597196a0b32);
        @(negedge clk);

        // R6 start while busy ignored
        p1 = 128'hdeadbeef0123456789abcdeffedcba98; k1 = 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0;
        run(p1, k1, 1, res, lat);
        exp = ref_enc(p1, k1);
        chk(res === exp, "R6 ignored start result", res, exp);
        chk(lat == 10, "R6 ignored start timing", 128'(lat), 128'd10);
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R6 no extra run", {busy, done}, 128'd0);

        // R8 back-to-back
        run(128'h1, 128'h2, 0, res, lat);
        exp = ref_enc(128'h1, 128'h2);
        chk(res === exp, "R8 first block", res, exp);
        run(128'h3, 128'h4, 0, res, lat);
        exp = ref_enc(128'h3, 128'h4);
        chk(res === exp, "R8 back-to-back block", res, exp);
        chk(lat == 10, "R8 back-to-back latency", 128'(lat), 128'd10);

        // R5 walking-bit sweeps over plaintext and key
        for (int b = 0; b < 128; b++) begin
            p1 = 128'h1 << b;
            run(p1, 128'h000102030405060708090a0b0c0d0e0f, 0, res, lat);
            exp = ref_enc(p1, 128'h000102030405060708090a0b0c0d0e0f);
            chk(res === exp, "R5 walking plaintext bit", res, exp);
        end
        for (int b = 0; b < 128; b++) begin
            k1 = 128'h1 << b;
            run(128'h00112233445566778899aabbccddeeff, k1, 0, res, lat);
            exp = ref_enc(128'h00112233445566778899aabbccddeeff, k1);
            chk(res === exp, "R5 walking key bit", res, exp);
        end
        for (int n = 0; n < 32; n++) begin
            p1 = {$urandom, $urandom, $urandom, $urandom};
            k1 = {$urandom, $urandom, $urandom, $urandom};
            run(p1, k1, 0, res, lat);
            exp = ref_enc(p1, k1);
            chk(res === exp, "R5 random block", res, exp);
            chk(lat == 10, "R3 random latency", 128'(lat), 128'd10);
        end
        run('1, '1, 0, res, lat);
        exp = ref_enc('1, '1);
        chk(res === exp, "R5 all ones", res, exp);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule